// File: doc/BRIEF.md
# Loop Bandwidth Mode Controller

This block decides, on every clock, whether a clock-synthesis PLL runs with its wide or its narrow loop bandwidth. Its one output, `narrow_bw`, would switch the loop-filter input resistor. The decision rests on two mode pins, a hitless-switching option enable, and a loss-of-lock flag. It also uses a strobe that marks each phase-detector comparison and a strobe that reports a single large phase error.

A lock-qualified state machine makes the decision. It counts consecutive phase-detector cycles with the loss-of-lock flag low. When the power-up override is enabled and narrow mode is requested, the block stays wide until eight such cycles have passed. After that it stays narrow for as long as narrow mode is requested. When wide mode is requested and the hitless option is on, the same run of eight locked cycles arms the hitless function. One large phase error then narrows the loop. The loop returns to wide only after a new run of eight locked cycles.

Top module: `bw_mode_ctrl`

## Requirements
- R1: While `init` is 0, `narrow_bw` is 0 in the same cycle. On the next edge the controller falls back to wide and disarmed, so a later rise of `init` starts from wide.
- R2: With `init`=1 and `nbw`=1, `narrow_bw` rises in the cycle after the eighth consecutive `pd_cycle_pulse` sampled with `lol`=0. After seven or fewer, it stays 0.
- R3: A `pd_cycle_pulse` that samples `lol`=1 restarts the locked run from zero. `lol`=1 with no `pd_cycle_pulse` leaves the run unchanged. The run count saturates at eight.
- R4: With `init`=1 and `nbw`=1, once `narrow_bw` is 1 it stays 1 whatever `lol` and `big_err_pulse` do.
- R5: With `nbw`=0 and `hs_en`=1, the hitless function arms on the eighth consecutive locked `pd_cycle_pulse`. Arming leaves `narrow_bw` at 0, and `big_err_pulse` has no effect while the function is unarmed.
- R6: When the function is armed, one `big_err_pulse` sets `narrow_bw` to 1 in the following cycle.
- R7: After a trigger, `narrow_bw` stays 1 until eight consecutive locked `pd_cycle_pulse`s have been counted from the trigger. It returns to 0 in the cycle after the eighth.
- R8: A trigger uses up the armed state. After the return to wide, `big_err_pulse` has no effect until a fresh run of eight locked cycles has re-armed the function.
- R9: With `nbw`=0 and `hs_en`=0, `narrow_bw` stays 0 under any locked runs and error strobes.
- R10: Reset clears the run count, disarms the hitless function and drives `narrow_bw` to 0.
- R11: If `nbw` falls while the loop is in continuous narrow mode, `narrow_bw` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nbw | input | 1 | 1 requests narrow bandwidth, 0 requests wide |
| init | input | 1 | 1 enables the power-up override, 0 forces wide |
| hs_en | input | 1 | Enables the hitless-switching option |
| lol | input | 1 | Loss-of-lock flag, 1 when unlocked |
| big_err_pulse | input | 1 | One-cycle strobe: a phase error above the trigger threshold |
| pd_cycle_pulse | input | 1 | One-cycle strobe: one phase-detector comparison |
| narrow_bw | output | 1 | 1 selects narrow loop bandwidth |

## Verification
The bench sweeps the length of the locked run from zero to past the threshold, both with narrow mode requested and with the hitless option on. A design with an off-by-one in the run comparison would narrow or arm one cycle early or late. Runs broken by a single unlocked comparison show whether the counter really restarts. Holding `lol` high without a strobe would catch a design that clears on the level of `lol` alone. After a trigger, the bench sends a second error strobe before re-arming and again after re-arming. A design that kept the armed state, or that re-armed from a count left over from before the trigger, would narrow again too early. Dropping `init` or `nbw` while the loop is narrow exposes a design that latches narrow mode.

// File: rtl/bw_mode_ctrl.sv
module bw_mode_ctrl #(
  parameter int LOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nbw,
  input  logic init,
  input  logic hs_en,
  input  logic lol,
  input  logic big_err_pulse,
  input  logic pd_cycle_pulse,
  output logic narrow_bw
);
  localparam int CW = $clog2(LOCK_RUN + 1);

  typedef enum logic [1:0] {S_WIDE, S_ARMED, S_FIXED, S_HOLD} st_t;

  st_t           state, state_nx;
  logic [CW-1:0] lock_cnt, cnt_nx;
  logic          run_done, clr;

  // this strobe completes (or extends) a full locked run
  assign run_done = pd_cycle_pulse && !lol && (lock_cnt >= CW'(LOCK_RUN - 1));

  always_comb begin
    state_nx = state;
    clr      = 1'b0;
    if (!init)
      state_nx = S_WIDE;
    else if (nbw) begin
      if (state == S_FIXED || state == S_HOLD || run_done) state_nx = S_FIXED;
      else                                                 state_nx = S_WIDE;
    end else if (!hs_en)
      state_nx = S_WIDE;
    else begin
      case (state)
        S_WIDE:  if (run_done) state_nx = S_ARMED;
        S_ARMED: if (big_err_pulse) begin state_nx = S_HOLD; clr = 1'b1; end
        S_HOLD:  if (run_done) begin state_nx = S_WIDE; clr = 1'b1; end
        default: state_nx = S_WIDE;
      endcase
    end
  end

  always_comb begin
    cnt_nx = lock_cnt;
    if (clr)                          cnt_nx = '0;
    else if (pd_cycle_pulse && lol)   cnt_nx = '0;
    else if (pd_cycle_pulse && lock_cnt != CW'(LOCK_RUN)) cnt_nx = lock_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_WIDE;
      lock_cnt <= '0;
    end else begin
      state    <= state_nx;
      lock_cnt <= cnt_nx;
    end
  end

  assign narrow_bw = init && (state == S_FIXED || state == S_HOLD);

  p_init_low_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> (state == S_WIDE));

  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cnt <= CW'(LOCK_RUN));

  p_lol_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_cycle_pulse && lol) |=> (lock_cnt == '0));

  p_fixed_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIXED && init && nbw) |=> (state == S_FIXED));

  p_arm_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_ARMED) ##1 (state == S_ARMED) |-> ($past(lock_cnt) >= CW'(LOCK_RUN - 1)));

  p_trigger_narrows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARMED && init && !nbw && hs_en && big_err_pulse) |=> narrow_bw);

  p_no_hs_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nbw && !hs_en) |=> (state == S_WIDE));
endmodule

// File: tb/bw_mode_ctrl_tb.sv
module bw_mode_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nbw = 1'b0, init = 1'b0, hs_en = 1'b0, lol = 1'b0;
  logic big_err_pulse = 1'b0, pd_cycle_pulse = 1'b0;
  logic narrow_bw;
  int   n_tests = 0, n_fail = 0;

  bw_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nbw(nbw), .init(init), .hs_en(hs_en),
    .lol(lol), .big_err_pulse(big_err_pulse), .pd_cycle_pulse(pd_cycle_pulse),
    .narrow_bw(narrow_bw)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic exp, input string req);
    n_tests++;
    if (narrow_bw !== exp) begin
      n_fail++;
      $display("FAIL %s narrow_bw actual=%b expected=%b t=%0t", req, narrow_bw, exp, $time);
    end
  endtask

  task automatic step(input logic pd, input logic l, input logic e);
    pd_cycle_pulse = pd; lol = l; big_err_pulse = e;
    @(posedge clk); @(negedge clk);
    pd_cycle_pulse = 1'b0; lol = 1'b0; big_err_pulse = 1'b0;
  endtask

  task automatic locked(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic do_reset(input logic i, input logic b, input logic h);
    init = i; nbw = b; hs_en = h;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state
    do_reset(1'b1, 1'b1, 1'b1);
    check(1'b0, "R10");

    // R2: sweep run length with narrow requested
    for (int n = 0; n <= 12; n++) begin
      do_reset(1'b1, 1'b1, 1'b0);
      locked(n);
      check(n >= 8, "R2");
    end

    // R3: broken run restarts; lol without strobe is ignored
    do_reset(1'b1, 1'b1, 1'b0);
    locked(5); step(1'b1, 1'b1, 1'b0); locked(7);
    check(1'b0, "R3");
    locked(1);
    check(1'b1, "R3");
    do_reset(1'b1, 1'b1, 1'b0);
    locked(7);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);
    locked(1);
    check(1'b1, "R3");

    // R4: continuous narrow ignores lol and errors
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1);
    check(1'b1, "R4");

    // R1: init low forces wide at once and restarts
    init = 1'b0; #1;
    check(1'b0, "R1");
    @(negedge clk); init = 1'b1; @(negedge clk);
    check(1'b0, "R1");
    locked(8);
    check(1'b1, "R1");

    // R11: nbw falling leaves continuous narrow
    nbw = 1'b0; @(negedge clk);
    check(1'b0, "R11");

    // R5/R6: arming sweep with hitless option
    for (int n = 0; n <= 11; n++) begin
      do_reset(1'b1, 1'b0, 1'b1);
      locked(n);
      check(1'b0, "R5");
      step(1'b0, 1'b0, 1'b1);
      check(n >= 8, "R6");
    end

    // R7: hold narrow until a fresh locked run after trigger
    do_reset(1'b1, 1'b0, 1'b1);
    locked(8); step(1'b0, 1'b0, 1'b1);
    locked(7);
    check(1'b1, "R7");
    step(1'b1, 1'b1, 1'b0);
    locked(7);
    check(1'b1, "R7");
    locked(1);
    check(1'b0, "R7");

    // R8: trigger consumed, re-arm needs a fresh run
    step(1'b0, 1'b0, 1'b1);
    check(1'b0, "R8");
    locked(7); step(1'b0, 1'b0, 1'b1);
    check(1'b0, "R8");
    locked(1); step(1'b0, 1'b0, 1'b1);
    check(1'b1, "R8");

    // R9: option off keeps wide
    do_reset(1'b1, 1'b0, 1'b0);
    locked(12); step(1'b0, 1'b0, 1'b1); step(1'b1, 1'b0, 1'b1);
    check(1'b0, "R9");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule